// File: doc/BRIEF.md
# CORDIC Vectoring Arctangent Unit

This block is a fully pipelined fixed-point CORDIC in vectoring mode. A signed (x, y) pair enters on each cycle that the input valid is high. The pipeline first turns left-half-plane vectors by a quarter turn. It then drives y toward zero over sixteen shift-add microrotations, accumulating the rotation angle as it goes. The result is the four-quadrant arctangent of y/x and the vector length. The length leaves the block with the CORDIC gain already divided out.

The gain is removed by a short chain of extra shift-add stages that scale by roughly 0.60725. No multiplier appears anywhere in the datapath. The angle is meant to be handed to a separate rotation unit that applies the same turn to other vectors. There is no handshake and no back-pressure: every accepted sample comes out a fixed number of cycles later.

Top module: `cordic_vec_atan`

## Requirements
- R1: angle_o equals atan2(y_i, x_i) in radians, as a 16-bit signed value with 13 fraction bits (pi is 25736). It is within 4 LSB of the exact value whenever the input magnitude is at least 1024.
- R2: r_o equals sqrt(x_i^2 + y_i^2) in input units, as a 17-bit unsigned value with the CORDIC gain removed. It is within 2 LSB of the exact value. Each gain-correction stage keeps its partial product between 0 and the uncorrected magnitude.
- R3: Inputs in every quadrant converge. A negative x_i is pre-rotated by a quarter turn, so the running x of every microrotation stage is non-negative. The input (-A, 0) gives +pi.
- R4: While out_valid_o is high, angle_o lies within plus or minus 25740.
- R5: A sample taken with in_valid_i high at clock edge k appears after edge k+19, with out_valid_o high for that one cycle. Samples taken on consecutive edges come out on consecutive cycles, in order.
- R6: rst_ni low clears out_valid_o at once, and this includes samples already in flight. Cycles with in_valid_i low produce no output.
- R7: Full-scale inputs, including -32768, do not overflow. r_o never exceeds 46345. The input (-32768, -32768) gives r_o = 46341 and angle_o = -19302.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| in_valid_i | input | 1 | Sample strobe for x_i and y_i |
| x_i | input | 16 | Signed x component |
| y_i | input | 16 | Signed y component |
| out_valid_o | output | 1 | Result strobe, in_valid_i delayed by 20 cycles |
| angle_o | output | 16 | Signed angle, radians, 13 fraction bits |
| r_o | output | 17 | Unsigned gain-corrected magnitude |

## Verification
Some properties are checked by assertions on every cycle:
- every microrotation stage holds a non-negative x after the quarter-turn pre-rotation;
- each gain stage keeps its partial product between zero and the carried magnitude;
- every valid angle stays within one half turn;
- every valid magnitude stays below the full-scale diagonal.

The numerical accuracy of angle and magnitude can only be shown by the bench's scenarios, which compare outputs against a real-valued reference. The same holds for the exact 20-cycle latency, in-order streaming, pi on the negative axis, and the loss of in-flight samples on reset.

// File: rtl/cordic_vec_pkg.sv
package cordic_vec_pkg;

  localparam int     TBL_FRAC    = 30;
  localparam int     TBL_ENTRIES = 16;
  localparam longint HALF_PI_Q30 = 64'sd1686629713;
  localparam int     GAIN_SLOTS  = 8;

  typedef enum logic [1:0] {PR_PASS, PR_CW, PR_CCW} prerot_e;

  // arctan(2^-idx) scaled by 2^30
  function automatic longint atan_q30(input int idx);
    case (idx)
      0:       atan_q30 = 64'sd843314857;
      1:       atan_q30 = 64'sd497837830;
      2:       atan_q30 = 64'sd263043837;
      3:       atan_q30 = 64'sd133525159;
      4:       atan_q30 = 64'sd67021687;
      5:       atan_q30 = 64'sd33543516;
      6:       atan_q30 = 64'sd16775851;
      7:       atan_q30 = 64'sd8388437;
      8:       atan_q30 = 64'sd4194283;
      9:       atan_q30 = 64'sd2097149;
      10:      atan_q30 = 64'sd1048576;
      11:      atan_q30 = 64'sd524288;
      12:      atan_q30 = 64'sd262144;
      13:      atan_q30 = 64'sd131072;
      14:      atan_q30 = 64'sd65536;
      15:      atan_q30 = 64'sd32768;
      default: atan_q30 = 64'sd0;
    endcase
  endfunction

  // round a Q30 constant down to frac fraction bits (frac < 30)
  function automatic longint requant(input longint v, input int frac);
    requant = (v + (64'sd1 <<< (TBL_FRAC - frac - 1))) >>> (TBL_FRAC - frac);
  endfunction

  // 1/K ~ 2^-1 + 2^-3 - 2^-6 - 2^-9 - 2^-13 - 2^-15 - 2^-16; shift 0 marks an empty slot
  function automatic int gain_shift(input int k);
    case (k)
      0:       gain_shift = 1;
      1:       gain_shift = 3;
      2:       gain_shift = 6;
      3:       gain_shift = 9;
      4:       gain_shift = 13;
      5:       gain_shift = 15;
      6:       gain_shift = 16;
      default: gain_shift = 0;
    endcase
  endfunction

  function automatic bit gain_sub(input int k);
    gain_sub = (k >= 2);
  endfunction

endpackage

// File: rtl/cordic_vec_prerot.sv
module cordic_vec_prerot
  import cordic_vec_pkg::*;
#(
  parameter int DW    = 16,
  parameter int IW    = 22,
  parameter int GUARD = 4,
  parameter int ZW    = 20,
  parameter int ZFRAC = 17
) (
  input  logic signed [DW-1:0] x_i,
  input  logic signed [DW-1:0] y_i,
  output logic signed [IW-1:0] x_o,
  output logic signed [IW-1:0] y_o,
  output logic signed [ZW-1:0] z_o
);

  localparam logic signed [ZW-1:0] HALF_PI = ZW'(requant(HALF_PI_Q30, ZFRAC));

  logic signed [IW-1:0] x_ext, y_ext;
  prerot_e              sel;

  assign x_ext = IW'(x_i) <<< GUARD;
  assign y_ext = IW'(y_i) <<< GUARD;

  always_comb begin
    if (!x_i[DW-1])      sel = PR_PASS;
    else if (!y_i[DW-1]) sel = PR_CW;
    else                 sel = PR_CCW;
  end

  always_comb begin
    unique case (sel)
      PR_CW: begin
        x_o = y_ext;
        y_o = -x_ext;
        z_o = HALF_PI;
      end
      PR_CCW: begin
        x_o = -y_ext;
        y_o = x_ext;
        z_o = -HALF_PI;
      end
      default: begin
        x_o = x_ext;
        y_o = y_ext;
        z_o = '0;
      end
    endcase
  end

endmodule

// File: rtl/cordic_vec_iter.sv
module cordic_vec_iter
  import cordic_vec_pkg::*;
#(
  parameter int IW    = 22,
  parameter int ZW    = 20,
  parameter int ZFRAC = 17,
  parameter int STAGE = 0
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 vld_i,
  input  logic signed [IW-1:0] x_i,
  input  logic signed [IW-1:0] y_i,
  input  logic signed [ZW-1:0] z_i,
  output logic                 vld_o,
  output logic signed [IW-1:0] x_o,
  output logic signed [IW-1:0] y_o,
  output logic signed [ZW-1:0] z_o
);

  localparam logic signed [ZW-1:0] ATAN_C = ZW'(requant(atan_q30(STAGE), ZFRAC));

  logic signed [IW-1:0] x_sh, y_sh, x_n, y_n;
  logic signed [ZW-1:0] z_n;

  assign x_sh = x_i >>> STAGE;
  assign y_sh = y_i >>> STAGE;

  // negative y: turn counter-clockwise, else clockwise
  always_comb begin
    if (y_i[IW-1]) begin
      x_n = x_i - y_sh;
      y_n = y_i + x_sh;
      z_n = z_i - ATAN_C;
    end else begin
      x_n = x_i + y_sh;
      y_n = y_i - x_sh;
      z_n = z_i + ATAN_C;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) vld_o <= 1'b0;
    else         vld_o <= vld_i;
  end

  always_ff @(posedge clk_i) begin
    x_o <= x_n;
    y_o <= y_n;
    z_o <= z_n;
  end

  // R3: pre-rotation leaves every stage in the right half plane
  p_x_nonneg_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_o |-> (x_o >= 0));

endmodule

// File: rtl/cordic_vec_gain.sv
module cordic_vec_gain
  import cordic_vec_pkg::*;
#(
  parameter int IW  = 22,
  parameter int ZW  = 20,
  parameter int IDX = 0
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 vld_i,
  input  logic signed [IW-1:0] mag_i,
  input  logic signed [IW-1:0] acc_i,
  input  logic signed [ZW-1:0] z_i,
  output logic                 vld_o,
  output logic signed [IW-1:0] mag_o,
  output logic signed [IW-1:0] acc_o,
  output logic signed [ZW-1:0] z_o
);

  localparam int TERMS = 2;

  logic signed [IW-1:0] term [TERMS];
  logic signed [IW-1:0] acc_n;

  for (genvar t = 0; t < TERMS; t++) begin : g_term
    localparam int  K  = IDX * TERMS + t;
    localparam int  SH = gain_shift(K);
    localparam bit  NG = gain_sub(K);
    if (SH == 0) begin : g_empty
      assign term[t] = '0;
    end else if (NG) begin : g_sub
      assign term[t] = -(mag_i >>> SH);
    end else begin : g_add
      assign term[t] = mag_i >>> SH;
    end
  end

  assign acc_n = acc_i + term[0] + term[1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) vld_o <= 1'b0;
    else         vld_o <= vld_i;
  end

  always_ff @(posedge clk_i) begin
    mag_o <= mag_i;
    acc_o <= acc_n;
    z_o   <= z_i;
  end

  // R2: partial scale factor stays in [0, 1)
  p_gain_bound_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_o |-> (acc_o >= 0) && (acc_o <= mag_o));

endmodule

// File: rtl/cordic_vec_atan.sv
module cordic_vec_atan
  import cordic_vec_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ANG_W  = 16,
  parameter int N_ITER = 16,
  parameter int GUARD  = 4
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     in_valid_i,
  input  logic signed [DATA_W-1:0] x_i,
  input  logic signed [DATA_W-1:0] y_i,
  output logic                     out_valid_o,
  output logic signed [ANG_W-1:0]  angle_o,
  output logic        [DATA_W:0]   r_o
);

  localparam int IW       = DATA_W + 2 + GUARD;
  localparam int ZG       = 4;
  localparam int ZW       = ANG_W + ZG;
  localparam int ANG_FRAC = ANG_W - 3;
  localparam int ZFRAC    = ANG_FRAC + ZG;
  localparam int GAIN_STG = GAIN_SLOTS / 2;
  localparam int R_W      = DATA_W + 1;
  localparam int PI_LSB   = int'(requant(2 * HALF_PI_Q30, ANG_FRAC));
  localparam longint R_MAX = ((64'sd1 <<< (DATA_W - 1)) * 14143) / 10000 + 2;

  localparam logic signed [IW-1:0] R_RND = IW'(1) <<< (GUARD - 1);
  localparam logic signed [ZW-1:0] Z_RND = ZW'(1) <<< (ZG - 1);

  logic                 it_v [N_ITER+1];
  logic signed [IW-1:0] it_x [N_ITER+1];
  logic signed [IW-1:0] it_y [N_ITER+1];
  logic signed [ZW-1:0] it_z [N_ITER+1];

  logic                 gn_v [GAIN_STG+1];
  logic signed [IW-1:0] gn_m [GAIN_STG+1];
  logic signed [IW-1:0] gn_a [GAIN_STG+1];
  logic signed [ZW-1:0] gn_z [GAIN_STG+1];

  assign it_v[0] = in_valid_i;

  cordic_vec_prerot #(
    .DW(DATA_W), .IW(IW), .GUARD(GUARD), .ZW(ZW), .ZFRAC(ZFRAC)
  ) u_prerot (
    .x_i(x_i), .y_i(y_i),
    .x_o(it_x[0]), .y_o(it_y[0]), .z_o(it_z[0])
  );

  for (genvar i = 0; i < N_ITER; i++) begin : g_iter
    cordic_vec_iter #(
      .IW(IW), .ZW(ZW), .ZFRAC(ZFRAC), .STAGE(i)
    ) u_iter (
      .clk_i(clk_i), .rst_ni(rst_ni),
      .vld_i(it_v[i]),   .x_i(it_x[i]),   .y_i(it_y[i]),   .z_i(it_z[i]),
      .vld_o(it_v[i+1]), .x_o(it_x[i+1]), .y_o(it_y[i+1]), .z_o(it_z[i+1])
    );
  end

  assign gn_v[0] = it_v[N_ITER];
  assign gn_m[0] = it_x[N_ITER];
  assign gn_a[0] = '0;
  assign gn_z[0] = it_z[N_ITER];

  for (genvar g = 0; g < GAIN_STG; g++) begin : g_gain
    cordic_vec_gain #(
      .IW(IW), .ZW(ZW), .IDX(g)
    ) u_gain (
      .clk_i(clk_i), .rst_ni(rst_ni),
      .vld_i(gn_v[g]),   .mag_i(gn_m[g]),   .acc_i(gn_a[g]),   .z_i(gn_z[g]),
      .vld_o(gn_v[g+1]), .mag_o(gn_m[g+1]), .acc_o(gn_a[g+1]), .z_o(gn_z[g+1])
    );
  end

  assign out_valid_o = gn_v[GAIN_STG];
  assign r_o         = R_W'((gn_a[GAIN_STG] + R_RND) >>> GUARD);
  assign angle_o     = ANG_W'((gn_z[GAIN_STG] + Z_RND) >>> ZG);

  // R4: result never leaves one half turn
  p_angle_range_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> (int'(angle_o) <= PI_LSB + 4) && (int'(angle_o) >= -PI_LSB - 4));

  // R7: no magnitude growth beyond the full-scale diagonal
  p_r_bound_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> (longint'(r_o) <= R_MAX));

endmodule

// File: tb/sim_cordic_vec_atan.sv
`timescale 1ns/1ps
module sim_cordic_vec_atan;

  localparam int LAT = 20;
  localparam int NV  = 12;
  localparam int VX [NV] = '{20000, 0, -20000, 12000, -12000, -12000, 12000, 32767, -32768, -32768, 1024, 0};
  localparam int VY [NV] = '{0, 20000, 0, 9000, 9000, -9000, -9000, 32767, -32768, 32767, -30000, -20000};

  logic               clk = 1'b0;
  logic               rst_n;
  logic               in_valid;
  logic signed [15:0] x, y;
  logic               out_valid;
  logic signed [15:0] angle;
  logic        [16:0] r;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  cordic_vec_atan u0 (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid),
    .x_i(x), .y_i(y),
    .out_valid_o(out_valid), .angle_o(angle), .r_o(r)
  );

  function automatic int rnd(input real v);
    rnd = (v >= 0.0) ? $rtoi(v + 0.5) : -$rtoi(-v + 0.5);
  endfunction

  function automatic int absd(input int a, input int b);
    absd = (a > b) ? a - b : b - a;
  endfunction

  task automatic check_bit(input logic got, input logic exp, input string tag);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s out_valid got %0b exp %0b", tag, got, exp);
    end
  endtask

  task automatic check_vec(input int vx, input int vy, input string tag);
    int ea, er, ga, gr;
    ea = rnd($atan2(real'(vy), real'(vx)) * 8192.0);
    er = rnd($sqrt(real'(vx) * real'(vx) + real'(vy) * real'(vy)));
    ga = int'(angle);
    gr = int'(r);
    checks++;
    if (absd(ga, ea) > 4) begin
      errors++;
      $display("FAIL R1 angle %s x=%0d y=%0d got %0d exp %0d", tag, vx, vy, ga, ea);
    end
    checks++;
    if (absd(gr, er) > 2) begin
      errors++;
      $display("FAIL R2 magnitude %s x=%0d y=%0d got %0d exp %0d", tag, vx, vy, gr, er);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n    = 1'b0;
    in_valid = 1'b0;
    x        = '0;
    y        = '0;
    repeat (3) @(negedge clk);
    check_bit(out_valid, 1'b0, "R6 reset");
    rst_n = 1'b1;

    // R6: idle input yields nothing
    begin
      logic seen;
      seen = 1'b0;
      for (int t = 0; t < LAT + 5; t++) begin
        @(negedge clk);
        if (out_valid) seen = 1'b1;
      end
      check_bit(seen, 1'b0, "R6 idle");
    end

    // table walked back-to-back: R1 R2 R3 R5 R7
    for (int t = 0; t < NV + LAT; t++) begin
      @(negedge clk);
      if (t >= LAT) begin
        int j;
        j = t - LAT;
        check_bit(out_valid, 1'b1, "R5 stream");
        if (VX[j] < 0 || (VX[j] == 0 && VY[j] != 0 && j == 1))
          check_vec(VX[j], VY[j], "R3 quadrant");
        else if (VX[j] == -32768 || VX[j] == 32767)
          check_vec(VX[j], VY[j], "R7 full-scale");
        else
          check_vec(VX[j], VY[j], "table");
      end else if (t == LAT - 1) begin
        check_bit(out_valid, 1'b0, "R5 stream early");
      end
      if (t < NV) begin
        in_valid = 1'b1;
        x = 16'(VX[t]);
        y = 16'(VY[t]);
      end else begin
        in_valid = 1'b0;
      end
    end

    // R3: negative axis gives +pi
    @(negedge clk);
    in_valid = 1'b1; x = -16'sd20000; y = 16'sd0;
    for (int t = 1; t <= LAT + 1; t++) begin
      @(negedge clk);
      if (t == 1) in_valid = 1'b0;
      if (t == LAT - 1) check_bit(out_valid, 1'b0, "R5 single early");
      if (t == LAT) begin
        check_bit(out_valid, 1'b1, "R5 single on time");
        checks++;
        if (absd(int'(angle), 25736) > 4) begin
          errors++;
          $display("FAIL R3 negative axis angle got %0d exp %0d", angle, 25736);
        end
      end
      if (t == LAT + 1) check_bit(out_valid, 1'b0, "R5 single one cycle");
    end

    // R7: corner value
    @(negedge clk);
    in_valid = 1'b1; x = -16'sd32768; y = -16'sd32768;
    for (int t = 1; t <= LAT; t++) begin
      @(negedge clk);
      if (t == 1) in_valid = 1'b0;
    end
    checks++;
    if (absd(int'(r), 46341) > 1 || absd(int'(angle), -19302) > 4) begin
      errors++;
      $display("FAIL R7 corner got r=%0d a=%0d exp r=46341 a=-19302", r, angle);
    end

    // R6: reset drops samples in flight
    for (int t = 0; t < 3; t++) begin
      @(negedge clk);
      in_valid = 1'b1; x = 16'sd5000; y = 16'sd5000;
    end
    @(negedge clk);
    in_valid = 1'b0;
    repeat (8) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check_bit(out_valid, 1'b0, "R6 mid reset");
    rst_n = 1'b1;
    begin
      logic seen;
      seen = 1'b0;
      for (int t = 0; t < LAT + 5; t++) begin
        @(negedge clk);
        if (out_valid) seen = 1'b1;
      end
      check_bit(seen, 1'b0, "R6 flushed");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule